// File: doc/BRIEF.md
# Character Fetch and NOP Substitution Unit

This block sits on the data path between a CPU and its memory in a text display that software drives. Display bytes are run through the CPU as if they were instructions. The CPU's program counter then walks the display buffer, and its refresh counter counts character positions along the line. When the CPU fetches an opcode from the upper half of the address space, the block takes the fetched byte as a character code. It keeps the code and hands the CPU a NOP (0x00) in its place. A byte with bit 6 set is the line terminator (0x76, a HALT opcode). That byte goes to the CPU untouched, so the CPU halts until the line is finished.

In the refresh cycle that follows a kept character, the block drives the low nine bits of the character-pattern ROM address. Bits 8..3 carry the six low bits of the code. Bits 2..0 carry a pixel-row counter that all characters on the scan line share. The CPU supplies the upper address bits itself during refresh. Bit 7 of the kept code is held as the inverse-video flag for that character. All strobes are active high and are sampled on the rising edge of `clk`.

The control is a two-state machine:
- IDLE moves to ARMED on a character fetch (transition CHAR_LATCH).
- ARMED stays in ARMED on a further character fetch (transition RELATCH).
- ARMED returns to IDLE after one refresh cycle (transition REFRESH_DONE).
- In every other cycle the state holds (transition WAIT).

Top module: `char_fetch_unit`

## Requirements
- R1: A character fetch is a cycle with `m1`, `mreq` and `cpu_a15` all 1 and `mem_data` bit 6 at 0. In that same cycle `cpu_data` is 0x00.
- R2: A fetch with `m1`, `mreq` and `cpu_a15` all 1 and `mem_data` bit 6 at 1 passes `mem_data` unchanged to `cpu_data`. Such a fetch does not arm the ROM address override.
- R3: In any cycle where `m1`, `mreq` or `cpu_a15` is 0, `cpu_data` equals `mem_data`.
- R4: In the first cycle after a character fetch where `rfsh` and `mreq` are both 1, `rom_addr_oe` is 1. In that cycle `rom_addr_lo` is {latched code bits 5..0, row counter}, with the code in bits 8..3 and the row in bits 2..0.
- R5: `rom_addr_oe` is 1 only in the refresh cycle described in R4, and only once per character fetch. Whenever `rom_addr_oe` is 0, `rom_addr_lo` is 0.
- R6: The row counter advances by one, modulo 8, on each cycle in which `hsync` is 1 after being 0 in the previous cycle.
- R7: While `vsync` is 1, the row counter is cleared to 0 at the next clock edge. This takes priority over an `hsync` rise.
- R8: From the clock edge of a character fetch, `inv_video` equals bit 7 of that fetched byte. It holds that value through all other cycles.
- R9: After reset, the state is IDLE, `rom_addr_oe` is 0, `inv_video` is 0 and the row counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_a15 | input | 1 | CPU address bit 15 (upper-half select) |
| m1 | input | 1 | Opcode-fetch strobe |
| mreq | input | 1 | Memory-request strobe |
| rfsh | input | 1 | Refresh strobe |
| mem_data | input | 8 | Byte from memory |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| cpu_data | output | 8 | Byte presented to the CPU |
| rom_addr_lo | output | 9 | Override for ROM address bits 8..0 |
| rom_addr_oe | output | 1 | Override enable for `rom_addr_lo` |
| inv_video | output | 1 | Inverse-video flag of the last character |

## Verification
The assertions check the following on every cycle:
- NOP substitution and terminator pass-through on fetch cycles.
- Pass-through on all other cycles.
- The override only ever appears inside a refresh cycle and never in two cycles in a row from one fetch.
- The row counter either steps on an `hsync` rise, clears under `vsync`, or holds.
- The inverse flag holds between fetches.

Some properties need whole scenarios, which only the bench provides:
- The ROM address carries the code bits and row bits in the right positions.
- The row wraps from 7 back to 0.
- A terminator does not arm the override.
- An idle cycle between a fetch and its refresh keeps the override armed.

// File: rtl/cf_pkg.sv
package cf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } fetch_state_t;
endpackage

// File: rtl/cf_bus_mux.sv
module cf_bus_mux #(
    parameter int DW       = 8,
    parameter int TERM_BIT = 6
) (
    input  logic          fetch,
    input  logic [DW-1:0] mem_data,
    output logic [DW-1:0] cpu_data,
    output logic          char_hit
);
    always_comb begin
        char_hit = fetch && !mem_data[TERM_BIT];
        cpu_data = char_hit ? '0 : mem_data;
    end
endmodule

// File: rtl/cf_row_counter.sv
module cf_row_counter #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             vsync,
    output logic [ROW_W-1:0] row
);
    logic             hs_q;
    logic [ROW_W-1:0] row_q;
    logic             hs_rise;

    assign hs_rise = hsync && !hs_q;
    assign row     = row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            row_q <= '0;
        end else begin
            hs_q <= hsync;
            if (vsync)        row_q <= '0;
            else if (hs_rise) row_q <= row_q + 1'b1;
        end
    end

    // R6: one step per hsync rise, wrapping at the counter width
    p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && !vsync) |=> (row_q == $past(row_q) + 1'b1));
    // R6: no movement without a rise
    p_row_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_rise && !vsync) |=> $stable(row_q));
    // R7: vertical sync clears
    p_vsync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (row_q == '0));
endmodule

// File: rtl/cf_fetch_ctrl.sv
module cf_fetch_ctrl
    import cf_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_hit,
    input  logic              refresh,
    input  logic [CODE_W-1:0] code_in,
    input  logic              inv_in,
    output logic [CODE_W-1:0] code,
    output logic              inv,
    output logic              drive
);
    fetch_state_t      state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              inv_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (char_hit) state_d = ST_ARMED;         // CHAR_LATCH
            ST_ARMED: begin
                if (char_hit)     state_d = ST_ARMED;           // RELATCH
                else if (refresh) state_d = ST_IDLE;            // REFRESH_DONE
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and character latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            inv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (char_hit) begin
                code_q <= code_in;
                inv_q  <= inv_in;
            end
        end
    end

    // outputs
    always_comb begin
        drive = 1'b0;
        unique case (state_q)
            ST_IDLE:  drive = 1'b0;
            ST_ARMED: drive = refresh;
            default:  drive = 1'b0;
        endcase
        code = code_q;
        inv  = inv_q;
    end

    // R4: a character fetch arms the override
    p_arm_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        char_hit |=> (state_q == ST_ARMED));
    // R8: the flag holds between character fetches
    p_inv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !char_hit |=> $stable(inv_q));
endmodule

// File: rtl/char_fetch_unit.sv
module char_fetch_unit #(
    parameter int DW       = 8,
    parameter int CODE_W   = 6,
    parameter int ROW_W    = 3,
    parameter int TERM_BIT = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_a15,
    input  logic                      m1,
    input  logic                      mreq,
    input  logic                      rfsh,
    input  logic [DW-1:0]             mem_data,
    input  logic                      hsync,
    input  logic                      vsync,
    output logic [DW-1:0]             cpu_data,
    output logic [CODE_W+ROW_W-1:0]   rom_addr_lo,
    output logic                      rom_addr_oe,
    output logic                      inv_video
);
    localparam int AW = CODE_W + ROW_W;

    logic              fetch;
    logic              char_hit;
    logic              refresh;
    logic [CODE_W-1:0] code;
    logic [ROW_W-1:0]  row;
    logic              drive;

    assign fetch   = m1 && mreq && cpu_a15;
    assign refresh = rfsh && mreq;

    cf_bus_mux #(.DW(DW), .TERM_BIT(TERM_BIT)) mux_i (
        .fetch    (fetch),
        .mem_data (mem_data),
        .cpu_data (cpu_data),
        .char_hit (char_hit)
    );

    cf_fetch_ctrl #(.CODE_W(CODE_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_hit (char_hit),
        .refresh  (refresh),
        .code_in  (mem_data[CODE_W-1:0]),
        .inv_in   (mem_data[DW-1]),
        .code     (code),
        .inv      (inv_video),
        .drive    (drive)
    );

    cf_row_counter #(.ROW_W(ROW_W)) row_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hsync (hsync),
        .vsync (vsync),
        .row   (row)
    );

    assign rom_addr_oe = drive;
    assign rom_addr_lo = drive ? {code, row} : {AW{1'b0}};

    // R1: characters become NOPs on the CPU side
    p_nop_sub_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !mem_data[TERM_BIT]) |-> (cpu_data == '0));
    // R2: the terminator reaches the CPU intact
    p_term_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && mem_data[TERM_BIT]) |-> (cpu_data == mem_data));
    // R3: non-display cycles are transparent
    p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |-> (cpu_data == mem_data));
    // R5: override only inside a refresh cycle
    p_oe_in_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr_oe |-> (rfsh && mreq));
    // R5: one refresh per fetch
    p_oe_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr_oe && !char_hit) |=> !rom_addr_oe);
    // R5: quiet address when not driving
    p_addr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_addr_oe |-> (rom_addr_lo == '0));
endmodule

// File: tb/char_fetch_unit_tb_top.sv
module char_fetch_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_a15 = 1'b0, m1 = 1'b0, mreq = 1'b0, rfsh = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic       hsync = 1'b0, vsync = 1'b0;
    logic [7:0] cpu_data;
    logic [8:0] rom_addr_lo;
    logic       rom_addr_oe;
    logic       inv_video;

    always #4 clk = ~clk;

    char_fetch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_a15(cpu_a15), .m1(m1), .mreq(mreq),
        .rfsh(rfsh), .mem_data(mem_data), .hsync(hsync), .vsync(vsync),
        .cpu_data(cpu_data), .rom_addr_lo(rom_addr_lo),
        .rom_addr_oe(rom_addr_oe), .inv_video(inv_video)
    );

    typedef struct {
        string      tag;
        logic [7:0] data;
        logic       oe;
        logic [8:0] addr;
        logic       inv;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // reference model state
    logic       m_armed = 0;
    logic [5:0] m_code  = 0;
    logic       m_inv   = 0;
    logic [2:0] m_row   = 0;
    logic       m_hs    = 0;

    task automatic bus(input logic a15, input logic m1_i, input logic mreq_i,
                       input logic rfsh_i, input logic [7:0] d,
                       input logic hs, input logic vs, input string tag);
        exp_t e;
        logic fch, chr, oe;
        @(negedge clk);
        cpu_a15 = a15; m1 = m1_i; mreq = mreq_i; rfsh = rfsh_i;
        mem_data = d; hsync = hs; vsync = vs;
        fch = m1_i && mreq_i && a15;
        chr = fch && !d[6];
        oe  = m_armed && rfsh_i && mreq_i;
        e.tag  = tag;
        e.data = chr ? 8'h00 : d;
        e.oe   = oe;
        e.addr = oe ? {m_code, m_row} : 9'h000;
        e.inv  = m_inv;
        q.push_back(e);
        if (chr) begin
            m_code = d[5:0]; m_inv = d[7]; m_armed = 1'b1;
        end else if (oe) begin
            m_armed = 1'b0;
        end
        if (vs) m_row = 3'd0;
        else if (hs && !m_hs) m_row = m_row + 3'd1;
        m_hs = hs;
    endtask

    task automatic idle(input string tag);
        bus(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic fetch_ref(input logic [7:0] d, input string tag);
        bus(1'b1, 1'b1, 1'b1, 1'b0, d, 1'b0, 1'b0, tag);
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares each cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total += 4;
                if (cpu_data !== e.data) begin
                    bad++; $display("FAIL %s cpu_data act=%h exp=%h", e.tag, cpu_data, e.data);
                end
                if (rom_addr_oe !== e.oe) begin
                    bad++; $display("FAIL %s rom_addr_oe act=%b exp=%b", e.tag, rom_addr_oe, e.oe);
                end
                if (rom_addr_lo !== e.addr) begin
                    bad++; $display("FAIL %s rom_addr_lo act=%h exp=%h", e.tag, rom_addr_lo, e.addr);
                end
                if (inv_video !== e.inv) begin
                    bad++; $display("FAIL %s inv_video act=%b exp=%b", e.tag, inv_video, e.inv);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle("R9");
        // R3: lower-half fetch and non-M1 upper access are transparent
        bus(1'b0, 1'b1, 1'b1, 1'b0, 8'h26, 1'b0, 1'b0, "R3");
        bus(1'b1, 1'b0, 1'b1, 1'b0, 8'h15, 1'b0, 1'b0, "R3");
        bus(1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, "R3");
        // R5: refresh without a prior fetch gives no override
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R5");
        // R1 / R4: character then refresh
        fetch_ref(8'h26, "R4");
        // R5: a second refresh is not driven
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R5");
        // R8: inverse character
        fetch_ref(8'h9A, "R8");
        // R2: terminator passes and does not arm
        bus(1'b1, 1'b1, 1'b1, 1'b0, 8'h76, 1'b0, 1'b0, "R2");
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R2");
        idle("R8");
        // R4: idle gap between fetch and refresh keeps the arm
        bus(1'b1, 1'b1, 1'b1, 1'b0, 8'h3F, 1'b0, 1'b0, "R1");
        idle("R4");
        bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R4");
        // R6: rows step on hsync rises and wrap after 8
        for (int i = 0; i < 10; i++) begin
            bus(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
            bus(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R6");
            fetch_ref(8'(i + 1), "R6");
        end
        // R7: vsync clears the row, even with an hsync rise
        bus(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R7");
        fetch_ref(8'h2C, "R7");
        idle("R7");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule